// File: doc/BRIEF.md
# Dithered multibit sigma-delta modulator

This block turns a stream of wide signed PCM samples, already raised to the oversampled rate, into a small signed code per sample. It does this with a first-order error-feedback loop, so the quantization error pushed into each code is carried to the next sample and shaped towards high frequencies. The few-bit output, rather than a single bit, keeps out-of-band noise lower for the element-matching stage that follows.

A pseudo-random dither word and a programmable DC offset are summed with the sample ahead of the quantizer. With both at zero the loop idles by alternating between two neighbouring codes. A small DC input then adds extra codes at nearly regular intervals, which is a tone. Dither randomizes those patterns, and the offset moves the operating point away from the noisy bands on either side of midscale. Samples enter through a valid/ready pair into a one-entry hold register. The loop advances exactly once per pulse of the per-sample strobe. A strobe with no fresh sample reuses the last accepted one.

The hold register is a two-state machine. In HOLD_EMPTY, `in_ready` is high. The transition *accept* (`in_valid` high) loads the sample and moves to HOLD_FULL. In HOLD_FULL, `in_ready` is low. The transition *consume* (`step_en` high) returns to HOLD_EMPTY.

Top module: `dsm_dither_mod`

## Requirements
- R1: While reset is low and after it is released, `code_out` is 0, `code_valid` is 0 and `in_ready` is 1. The error state is cleared and the LFSR holds a nonzero seed.
- R2: A sample is taken when `in_valid` and `in_ready` are both high at a clock edge. After that, `in_ready` stays low until a strobe consumes the sample. A strobe in HOLD_EMPTY uses the previously accepted sample (zero after reset), even if a new sample is accepted at the same edge.
- R3: On each edge with `step_en` high, the loop updates once, and `code_valid` is high during the following cycle. With `step_en` low, `code_valid` is low next cycle and `code_out` keeps its value.
- R4: `code_out` is 4-bit two's complement and always takes an odd value from -7 to +7. Code c stands for the level c*2^20. The code chosen is 2*floor(v/2^21)+1, saturated to the range -7..+7, where v is the sum of sample, offset, dither and carried error, all in units of the 24-bit input.
- R5: The carried error is v minus the chosen level, clamped to the range -2^21 .. 2^21-1. It is added at the next strobe.
- R6: With zero input, zero offset and dither off, the codes after reset alternate +1, -1, +1, ... with +1 first.
- R7: With dither off and a constant input x, the mean of 4096 consecutive codes lies within 1 of x/2^20.
- R8: `dc_offset` (signed 24-bit) is added to the sample at every strobe. A zero input with offset d gives the same codes as input d with no offset.
- R9: With `dither_shift` s in 1..15, a dither term is added. It is the 23-bit LFSR state read as signed, shifted right arithmetically by 16-s. The LFSR shifts left once per strobe and inserts bit22 XOR bit17; its seed is 23'h35A1C7. With s = 0 the dither term is zero.
- R10: A full-scale positive input (2^23-1) gives +7 on every strobe, and a full-scale negative input (-2^23) gives -7 on every strobe. Once the input returns to zero, the clamp in R5 lets the loop recover at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Hold register empty, sample can be taken |
| in_sample | input | 24 | Signed PCM sample |
| step_en | input | 1 | Per-sample strobe, one loop update per cycle high |
| dither_shift | input | 4 | Dither amplitude control, 0 disables |
| dc_offset | input | 24 | Signed DC offset added ahead of the quantizer |
| code_out | output | 4 | Signed odd output code, -7..+7 |
| code_valid | output | 1 | High the cycle after a loop update |

## Verification
The loop is run with several inputs, each separating one behaviour:
- A zero input shows the idle alternation.
- Constant DC inputs near a code and just off zero check that the error feedback keeps the long-run mean right; a wrong error sign or a missing carry drifts the mean.
- A zero input with an offset is compared against the model to show that the offset enters the sum.
- Two dither amplitudes are compared bit for bit, which pins down the LFSR taps and the shift direction.
- Full-scale inputs of both polarities, followed by zero, show saturation and whether the error clamp lets the loop recover.
- Irregular strobe timing shows the hold register's reuse and blocking: a strobe without a new sample, an accept and strobe in the same cycle, and a sample held while the register is full.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    typedef enum logic [0:0] {
        HOLD_EMPTY = 1'b0,
        HOLD_FULL  = 1'b1
    } hold_state_t;

endpackage

// File: rtl/dsm_sample_hold.sv
module dsm_sample_hold #(
    parameter int W_IN = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [W_IN-1:0] in_sample,
    input  logic                   step_en,
    output logic                   in_ready,
    output logic signed [W_IN-1:0] held_sample
);
    import dsm_pkg::*;

    hold_state_t state_q, state_d;
    logic        load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HOLD_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            HOLD_EMPTY: begin
                if (in_valid) begin
                    load    = 1'b1;
                    state_d = HOLD_FULL;
                end
            end
            HOLD_FULL: begin
                if (step_en) begin
                    state_d = HOLD_EMPTY;
                end
            end
            default: state_d = HOLD_EMPTY;
        endcase
    end

    always_comb begin
        unique case (state_q)
            HOLD_EMPTY: in_ready = 1'b1;
            HOLD_FULL:  in_ready = 1'b0;
            default:    in_ready = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_sample <= '0;
        end else if (load) begin
            held_sample <= in_sample;
        end
    end

endmodule

// File: rtl/dsm_dither.sv
module dsm_dither #(
    parameter int               LFSR_W    = 23,
    parameter int               TAP_B     = 17,
    parameter logic [LFSR_W-1:0] SEED     = 23'h35A1C7,
    parameter int               SH_W      = 4,
    parameter int               DITH_BASE = 16,
    parameter int               OUT_W     = 27
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    advance,
    input  logic [SH_W-1:0]         shift,
    output logic signed [OUT_W-1:0] dither_out,
    output logic [LFSR_W-1:0]       lfsr_state
);
    localparam int N_SH = 1 << SH_W;

    logic [LFSR_W-1:0]       lfsr_q;
    logic                    feedback;
    logic signed [OUT_W-1:0] lfsr_ext;
    logic signed [OUT_W-1:0] cand [N_SH];

    assign feedback = lfsr_q[LFSR_W-1] ^ lfsr_q[TAP_B];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else if (advance) begin
            lfsr_q <= {lfsr_q[LFSR_W-2:0], feedback};
        end
    end

    assign lfsr_ext = OUT_W'($signed(lfsr_q));

    assign cand[0] = '0;
    for (genvar g = 1; g < N_SH; g++) begin : g_scale
        assign cand[g] = lfsr_ext >>> (DITH_BASE - g);
    end

    assign dither_out = cand[shift];
    assign lfsr_state = lfsr_q;

endmodule

// File: rtl/dsm_loop.sv
module dsm_loop #(
    parameter int W_IN   = 24,
    parameter int W_CODE = 4,
    parameter int W_SUM  = W_IN + 3,
    parameter int W_ERR  = W_IN - W_CODE + 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_en,
    input  logic signed [W_IN-1:0]   sample,
    input  logic signed [W_IN-1:0]   offset,
    input  logic signed [W_SUM-1:0]  dither,
    output logic signed [W_CODE-1:0] code_out,
    output logic                     code_valid,
    output logic signed [W_ERR-1:0]  err_state
);
    localparam int LSB_SH = W_IN - W_CODE;
    localparam int Q_SH   = LSB_SH + 1;
    localparam logic signed [W_SUM-1:0] Q_HI   = W_SUM'((1 <<< (W_CODE - 2)) - 1);
    localparam logic signed [W_SUM-1:0] Q_LO   = -(W_SUM'(1 <<< (W_CODE - 2)));
    localparam logic signed [W_SUM-1:0] ERR_HI = W_SUM'((1 <<< Q_SH) - 1);
    localparam logic signed [W_SUM-1:0] ERR_LO = -(W_SUM'(1 <<< Q_SH));
    localparam logic signed [W_CODE-1:0] C_HI  = W_CODE'((1 <<< (W_CODE - 1)) - 1);
    localparam logic signed [W_CODE-1:0] C_LO  = -C_HI;

    logic signed [W_SUM-1:0]  v_sum;
    logic signed [W_SUM-1:0]  q_idx;
    logic signed [W_SUM-1:0]  level;
    logic signed [W_SUM-1:0]  resid;
    logic signed [W_SUM-1:0]  resid_cl;
    logic signed [W_CODE-1:0] code_d;
    logic signed [W_ERR-1:0]  err_q;

    always_comb begin
        v_sum = W_SUM'(sample) + W_SUM'(offset) + dither + W_SUM'(err_q);
        q_idx = v_sum >>> Q_SH;
        if (q_idx >= Q_HI) begin
            code_d = C_HI;
        end else if (q_idx <= Q_LO) begin
            code_d = C_LO;
        end else begin
            code_d = W_CODE'((q_idx <<< 1) + W_SUM'(1));
        end
        level = W_SUM'(code_d) <<< LSB_SH;
        resid = v_sum - level;
        if (resid > ERR_HI) begin
            resid_cl = ERR_HI;
        end else if (resid < ERR_LO) begin
            resid_cl = ERR_LO;
        end else begin
            resid_cl = resid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q      <= '0;
            code_out   <= '0;
            code_valid <= 1'b0;
        end else begin
            code_valid <= step_en;
            if (step_en) begin
                err_q    <= W_ERR'(resid_cl);
                code_out <= code_d;
            end
        end
    end

    assign err_state = err_q;

endmodule

// File: rtl/dsm_dither_mod.sv
module dsm_dither_mod #(
    parameter int               W_IN   = 24,
    parameter int               W_CODE = 4,
    parameter int               SH_W   = 4,
    parameter int               LFSR_W = 23,
    parameter logic [LFSR_W-1:0] SEED  = 23'h35A1C7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [W_IN-1:0]   in_sample,
    input  logic              step_en,
    input  logic [SH_W-1:0]   dither_shift,
    input  logic [W_IN-1:0]   dc_offset,
    output logic [W_CODE-1:0] code_out,
    output logic              code_valid
);
    localparam int W_SUM = W_IN + 3;
    localparam int W_ERR = W_IN - W_CODE + 3;

    logic signed [W_IN-1:0]   held_w;
    logic signed [W_SUM-1:0]  dither_w;
    logic [LFSR_W-1:0]        lfsr_w;
    logic signed [W_ERR-1:0]  err_w;
    logic signed [W_CODE-1:0] code_w;

    dsm_sample_hold #(.W_IN(W_IN)) i_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_sample   ($signed(in_sample)),
        .step_en     (step_en),
        .in_ready    (in_ready),
        .held_sample (held_w)
    );

    dsm_dither #(
        .LFSR_W    (LFSR_W),
        .TAP_B     (LFSR_W - 6),
        .SEED      (SEED),
        .SH_W      (SH_W),
        .DITH_BASE (1 << SH_W),
        .OUT_W     (W_SUM)
    ) i_dither (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (step_en),
        .shift      (dither_shift),
        .dither_out (dither_w),
        .lfsr_state (lfsr_w)
    );

    dsm_loop #(
        .W_IN   (W_IN),
        .W_CODE (W_CODE),
        .W_SUM  (W_SUM),
        .W_ERR  (W_ERR)
    ) i_loop (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .sample     (held_w),
        .offset     ($signed(dc_offset)),
        .dither     (dither_w),
        .code_out   (code_w),
        .code_valid (code_valid),
        .err_state  (err_w)
    );

    assign code_out = code_w;

endmodule

// File: rtl/dsm_checker.sv
module dsm_checker #(
    parameter int W_CODE = 4,
    parameter int W_ERR  = 23,
    parameter int LFSR_W = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              step_en,
    input logic [W_CODE-1:0] code_out,
    input logic              code_valid,
    input logic [W_ERR-1:0]  err_state,
    input logic [LFSR_W-1:0] lfsr_state
);
    localparam int ERR_SH = W_ERR - 2;
    localparam logic signed [W_ERR-1:0]  E_HI = W_ERR'((1 <<< ERR_SH) - 1);
    localparam logic signed [W_ERR-1:0]  E_LO = -(W_ERR'(1 <<< ERR_SH));
    localparam logic signed [W_CODE-1:0] C_HI = W_CODE'((1 <<< (W_CODE - 1)) - 1);

    AST_CODE_ODD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> (code_out[0] && ($signed(code_out) <= C_HI) && ($signed(code_out) >= -C_HI))); // R4

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> code_valid); // R3

    AST_QUIET_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> (!code_valid && $stable(code_out))); // R3

    AST_ERR_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(err_state) <= E_HI) && ($signed(err_state) >= E_LO)); // R5

    AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0); // R9

    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R2

    AST_CONSUME_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && step_en) |=> in_ready); // R2

endmodule

bind dsm_dither_mod dsm_checker #(
    .W_CODE (W_CODE),
    .W_ERR  (W_IN - W_CODE + 3),
    .LFSR_W (LFSR_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .step_en    (step_en),
    .code_out   (code_out),
    .code_valid (code_valid),
    .err_state  (err_w),
    .lfsr_state (lfsr_w)
);

// File: tb/test_dsm_dither_mod.sv
`timescale 1ns/1ps
module test_dsm_dither_mod;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_sample = '0;
    logic        step_en = 1'b0;
    logic [3:0]  dither_shift = '0;
    logic [23:0] dc_offset = '0;
    logic [3:0]  code_out;
    logic        code_valid;

    always #5 clk = ~clk;

    dsm_dither_mod i_dsm_dither_mod (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_sample    (in_sample),
        .step_en      (step_en),
        .dither_shift (dither_shift),
        .dc_offset    (dc_offset),
        .code_out     (code_out),
        .code_valid   (code_valid)
    );

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [22:0] m_lfsr;
    longint      m_err, m_held;
    bit          m_full;
    logic [3:0]  exp_code;
    bit          exp_valid, exp_ready;

    function automatic longint q_code(longint v);
        longint q, y;
        q = v >>> 21;
        y = 2 * q + 1;
        if (y > 7) y = 7;
        if (y < -7) y = -7;
        return y;
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_lfsr = 23'h35A1C7; m_err = 0; m_held = 0; m_full = 0;
            exp_code = 4'd0; exp_valid = 0; exp_ready = 1;
        end else begin
            if (step_en) begin
                longint d, v, y, e, l;
                l = longint'($signed(m_lfsr));
                d = (dither_shift == 0) ? 0 : (l >>> (16 - dither_shift));
                v = m_held + longint'($signed(dc_offset)) + d + m_err;
                y = q_code(v);
                e = v - y * (64'sd1 <<< 20);
                if (e > (64'sd1 <<< 21) - 1) e = (64'sd1 <<< 21) - 1;
                if (e < -(64'sd1 <<< 21)) e = -(64'sd1 <<< 21);
                m_err = e;
                exp_code = y[3:0];
                exp_valid = 1;
                m_lfsr = {m_lfsr[21:0], m_lfsr[22] ^ m_lfsr[17]};
            end else begin
                exp_valid = 0;
            end
            if (!m_full && in_valid) begin
                m_held = longint'($signed(in_sample));
                m_full = 1;
            end else if (m_full && step_en) begin
                m_full = 0;
            end
            exp_ready = !m_full;
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (code_out !== exp_code || code_valid !== exp_valid || in_ready !== exp_ready) begin
                errors++;
                $display("FAIL %s model: code=%0d valid=%0b ready=%0b expected code=%0d valid=%0b ready=%0b",
                         cur_req, $signed(code_out), code_valid, in_ready,
                         $signed(exp_code), exp_valid, exp_ready);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=below 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check_val(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // offer a sample, let it load, strobe, return the fresh code
    task automatic do_sample(input logic [23:0] x, output int code);
        in_valid = 1; in_sample = x;
        @(negedge clk);
        in_valid = 0; step_en = 1;
        @(negedge clk);
        step_en = 0;
        code = $signed(code_out);
    endtask

    task automatic strobe_only();
        step_en = 1;
        @(negedge clk);
        step_en = 0;
        @(negedge clk);
    endtask

    task automatic mean_test(string req, logic [23:0] x, int n);
        longint sum = 0;
        real mean, target;
        int c;
        for (int i = 0; i < n; i++) begin
            do_sample(x, c);
            sum += c;
        end
        mean = real'(sum) / real'(n);
        target = (real'(longint'($signed(x))) + real'(longint'($signed(dc_offset)))) / 1048576.0;
        checks++;
        if (mean > target + 1.0 || mean < target - 1.0) begin
            errors++;
            $display("FAIL %s mean: actual=%f expected=%f", req, mean, target);
        end
    endtask

    initial begin
        int c;
        // R1: reset state
        repeat (3) @(negedge clk);
        check_val("R1 code", code_out, 0);
        check_val("R1 valid", code_valid, 0);
        check_val("R1 ready", in_ready, 1);
        rst_n = 1;
        @(negedge clk);
        check_val("R1 after release", {code_out, code_valid, in_ready}, 1);

        // R6: idle alternation
        cur_req = "R6";
        for (int i = 0; i < 16; i++) begin
            do_sample(24'd0, c);
            check_val("R6 alternation", c, (i % 2 == 0) ? 1 : -1);
        end

        // R7: DC tracking, dither off (also exercises R4 and R5 via the model)
        cur_req = "R7";
        mean_test("R7 pos", 24'd3158000, 4096);
        mean_test("R7 neg", -24'sd100000, 4096);

        // R8: offset alone
        cur_req = "R8";
        dc_offset = 24'd2102000;
        mean_test("R8 offset", 24'd0, 1024);
        dc_offset = '0;

        // R9: dither at two amplitudes, bit exact against the model
        cur_req = "R9";
        dither_shift = 4'd15;
        for (int i = 0; i < 512; i++) do_sample(24'd1000, c);
        dither_shift = 4'd7;
        for (int i = 0; i < 256; i++) do_sample(-24'sd3000000, c);
        dither_shift = 4'd0;

        // R10: saturation and recovery
        cur_req = "R10";
        for (int i = 0; i < 32; i++) begin
            do_sample(24'h7FFFFF, c);
            check_val("R10 pos sat", c, 7);
        end
        for (int i = 0; i < 8; i++) do_sample(24'h800000, c);
        for (int i = 0; i < 24; i++) begin
            do_sample(24'h800000, c);
            check_val("R10 neg sat", c, -7);
        end
        for (int i = 0; i < 32; i++) do_sample(24'd0, c);

        // R2 / R3: hold register behaviour and irregular strobes
        cur_req = "R2";
        do_sample(24'd5242880, c);
        strobe_only();
        strobe_only();
        check_val("R2 reuse ready", in_ready, 1);
        in_valid = 1; in_sample = -24'sd4194304; step_en = 1;
        @(negedge clk);
        step_en = 0; in_sample = 24'd6291456;
        @(negedge clk);
        check_val("R2 blocked while full", in_ready, 0);
        @(negedge clk);
        step_en = 1;
        @(negedge clk);
        step_en = 0;
        @(negedge clk);
        in_valid = 0;
        cur_req = "R3";
        repeat (5) @(negedge clk);
        check_val("R3 no strobe no valid", code_valid, 0);
        strobe_only();
        repeat (3) begin
            step_en = 1;
            @(negedge clk);
        end
        step_en = 0;
        repeat (4) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule